// File: doc/BRIEF.md
# SDRAM Clock-Enable Power Mode Tracker

This block sits beside the command bus of a single-data-rate synchronous DRAM and follows, one clock at a time, which low-power condition the memory is in. It has four modes: normal operation, power-down, self-refresh and clock suspend. Every clock it looks at the registered clock-enable level from the previous cycle and from the current cycle. It also looks at the chip-select, row-strobe, column-strobe and write-enable lines sampled in the current cycle, and at an all-banks-idle indication that an external bank tracker supplies.

From that information the block moves between modes. It raises a one-cycle flag when the command and clock-enable pattern is not allowed in the present mode. After a self-refresh exit it keeps a busy flag high for a row-cycle recovery window. While that flag is high, the controller may issue only deselect or no-operation cycles. The controller reads the mode to decide which commands it may issue. A monitor can use the illegal flag to catch protocol slips.

Top module: `sdr_cke_mode_tracker`

## Requirements
- R1: After reset the mode output is 0 (normal), and illegal and busy are both 0.
- R2: The mode codes are 0 normal, 1 power-down, 2 self-refresh and 3 clock suspend. In normal mode with banks idle and busy low, a falling clock enable (previous 1, current 1→0) moves the mode to 1 on the next cycle when the command is deselect (chip select 1) or no-operation (chip select 0, the three strobes 1).
- R3: In normal mode with banks idle and busy low, a falling clock enable with the refresh pattern moves the mode to 2. The refresh pattern is chip select 0, row strobe 0, column strobe 0, write 1. A falling clock enable with any other command raises illegal for one cycle and leaves the mode at 0.
- R4: In normal mode with banks not idle and busy low, a falling clock enable moves the mode to 3. Modes 1 and 2 are never entered unless banks idle was high.
- R5: In mode 3 the mode stays at 3 while the current clock enable is low. It returns to 0 on the cycle after the current clock enable is high.
- R6: In mode 1, previous clock enable 0 with current 1 and a deselect or no-operation returns the mode to 0. Busy stays 0.
- R7: In mode 2, previous clock enable 0 with current 1 and a deselect or no-operation returns the mode to 0. Busy is then high for exactly TRC_CYC cycles.
- R8: In modes 1 and 2, a rising clock enable with any other command raises illegal and keeps the mode. With both clock-enable samples 0, the mode is kept and no command causes illegal.
- R9: In modes 1 and 2, a previous clock enable of 1 is invalid: illegal is raised and the mode is kept.
- R10: While busy is high the mode stays 0. Any command other than deselect or no-operation raises illegal, and so does a falling clock enable.
- R11: In normal mode with busy low, both clock-enable samples 1, or a previous sample of 0, leave the mode unchanged without illegal.
- R12: Illegal and mode are registered. Each reflects only the inputs of the preceding clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke_prev | input | 1 | Registered clock enable of the previous cycle |
| cke_now | input | 1 | Registered clock enable of the current cycle |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| banks_idle | input | 1 | High when every bank is idle |
| mode | output | 2 | Current power mode code |
| illegal | output | 1 | One-cycle flag for a disallowed pattern |
| busy | output | 1 | High during self-refresh exit recovery |

## Verification
The assertions do not assume that cke_prev repeats the previous cke_now. They also do not assume that banks_idle agrees with the command history, because the block must judge whatever pattern the bus shows. To reach the low-power modes often, the stimulus keeps cke_prev equal to the last driven cke_now in most cycles. It breaks that link on purpose now and then so that the invalid-previous case (R9) occurs. Commands are weighted toward deselect, no-operation and refresh, so that self-refresh entries and exits with their recovery window occur many times.

// File: rtl/sdr_cke_pkg.sv
package sdr_cke_pkg;

  typedef enum logic [1:0] {
    PM_NORMAL  = 2'd0,
    PM_PDOWN   = 2'd1,
    PM_SREF    = 2'd2,
    PM_SUSPEND = 2'd3
  } pmode_t;

  // Deselect or no-operation: both leave the device untouched.
  function automatic logic cmd_is_quiet(input logic cs_n, input logic ras_n,
                                        input logic cas_n, input logic we_n);
    return cs_n | (ras_n & cas_n & we_n);
  endfunction

  // Auto-refresh encoding, also used to enter self-refresh.
  function automatic logic cmd_is_refresh(input logic cs_n, input logic ras_n,
                                          input logic cas_n, input logic we_n);
    return ~cs_n & ~ras_n & ~cas_n & we_n;
  endfunction

  // Counter width large enough to hold a recovery length.
  function automatic int unsigned cnt_width(input int unsigned cycles);
    return (cycles < 2) ? 1 : $clog2(cycles + 1);
  endfunction

endpackage

// File: rtl/sdr_cmd_classify.sv
module sdr_cmd_classify
  import sdr_cke_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output logic quiet,
  output logic refresh
);

  always_comb begin
    quiet   = cmd_is_quiet(cs_n, ras_n, cas_n, we_n);
    refresh = cmd_is_refresh(cs_n, ras_n, cas_n, we_n);
  end

endmodule

// File: rtl/sdr_exit_recovery.sv
module sdr_exit_recovery
  import sdr_cke_pkg::*;
#(
  parameter int unsigned TRC_CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);

  localparam int unsigned CNT_W = cnt_width(TRC_CYC);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(TRC_CYC);

  logic [CNT_W-1:0] cnt_q;
  logic             cnt_nonzero;

  assign cnt_nonzero = (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (load)       cnt_q <= LOAD_VAL;
    else if (cnt_nonzero) cnt_q <= cnt_q - 1'b1;
  end

  assign busy = cnt_nonzero;

  AST_LOAD_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (load && TRC_CYC > 0) |=> busy);  // R7

  AST_COUNT_STEPS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_nonzero && !load) |=> (cnt_q == $past(cnt_q) - 1'b1));  // R7

endmodule

// File: rtl/sdr_pmode_fsm.sv
module sdr_pmode_fsm
  import sdr_cke_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cke_prev,
  input  logic   cke_now,
  input  logic   quiet,
  input  logic   refresh,
  input  logic   banks_idle,
  input  logic   busy,
  output pmode_t mode_q,
  output logic   illegal_q,
  output logic   sref_exit
);

  pmode_t mode_d;
  logic   illegal_d;
  logic   cke_fall;
  logic   cke_rise;
  logic   cke_low;

  assign cke_fall = cke_prev & ~cke_now;
  assign cke_rise = ~cke_prev & cke_now;
  assign cke_low  = ~cke_prev & ~cke_now;

  always_comb begin
    mode_d    = mode_q;
    illegal_d = 1'b0;
    sref_exit = 1'b0;
    unique case (mode_q)
      PM_NORMAL: begin
        if (busy) begin
          if (!quiet || cke_fall) illegal_d = 1'b1;
        end else if (cke_fall) begin
          if (!banks_idle)  mode_d    = PM_SUSPEND;
          else if (quiet)   mode_d    = PM_PDOWN;
          else if (refresh) mode_d    = PM_SREF;
          else              illegal_d = 1'b1;
        end
      end
      PM_PDOWN, PM_SREF: begin
        if (cke_prev) begin
          illegal_d = 1'b1;
        end else if (cke_rise) begin
          if (quiet) begin
            mode_d    = PM_NORMAL;
            sref_exit = (mode_q == PM_SREF);
          end else begin
            illegal_d = 1'b1;
          end
        end
      end
      PM_SUSPEND: begin
        if (cke_now) mode_d = PM_NORMAL;
      end
      default: mode_d = PM_NORMAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= PM_NORMAL;
      illegal_q <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      illegal_q <= illegal_d;
    end
  end

  AST_LOWPWR_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PM_NORMAL && !banks_idle) |=>
      (mode_q == PM_NORMAL || mode_q == PM_SUSPEND));  // R4

  AST_LOW_CKE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == PM_PDOWN || mode_q == PM_SREF) && cke_low) |=>
      ($stable(mode_q) && !illegal_q));  // R8

  AST_PREV_HIGH_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == PM_PDOWN || mode_q == PM_SREF) && cke_prev) |=>
      (illegal_q && $stable(mode_q)));  // R9

  AST_STEADY_HIGH_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PM_NORMAL && !busy && cke_prev && cke_now) |=>
      (mode_q == PM_NORMAL && !illegal_q));  // R11

  AST_SUSPEND_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PM_SUSPEND && cke_now) |=> (mode_q == PM_NORMAL));  // R5

endmodule

// File: rtl/sdr_cke_mode_tracker.sv
module sdr_cke_mode_tracker
  import sdr_cke_pkg::*;
#(
  parameter int unsigned TRC_CYC = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cke_prev,
  input  logic       cke_now,
  input  logic       cs_n,
  input  logic       ras_n,
  input  logic       cas_n,
  input  logic       we_n,
  input  logic       banks_idle,
  output logic [1:0] mode,
  output logic       illegal,
  output logic       busy
);

  logic   cmd_quiet;
  logic   cmd_refresh;
  logic   sref_exit;
  logic   busy_w;
  pmode_t mode_w;

  sdr_cmd_classify u_classify (
    .cs_n    (cs_n),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .we_n    (we_n),
    .quiet   (cmd_quiet),
    .refresh (cmd_refresh)
  );

  sdr_pmode_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .cke_prev   (cke_prev),
    .cke_now    (cke_now),
    .quiet      (cmd_quiet),
    .refresh    (cmd_refresh),
    .banks_idle (banks_idle),
    .busy       (busy_w),
    .mode_q     (mode_w),
    .illegal_q  (illegal),
    .sref_exit  (sref_exit)
  );

  sdr_exit_recovery #(.TRC_CYC(TRC_CYC)) u_recovery (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (sref_exit),
    .busy  (busy_w)
  );

  assign mode = mode_w;
  assign busy = busy_w;

  AST_BUSY_ONLY_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (mode == 2'd0));  // R10

  AST_BUSY_BAD_CMD_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cmd_quiet) |=> illegal);  // R10

  AST_PDOWN_EXIT_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && !cke_prev && cke_now && cmd_quiet) |=>
      (mode == 2'd0 && !busy));  // R6

endmodule

// File: tb/sdr_cke_mode_tracker_bench.sv
module sdr_cke_mode_tracker_bench;

  localparam int TRC = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke_prev = 1'b1, cke_now = 1'b1;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic banks_idle = 1'b1;
  logic [1:0] mode;
  logic illegal, busy;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sdr_cke_mode_tracker #(.TRC_CYC(TRC)) u_sdr_cke_mode_tracker (
    .clk(clk), .rst_n(rst_n), .cke_prev(cke_prev), .cke_now(cke_now),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .banks_idle(banks_idle), .mode(mode), .illegal(illegal), .busy(busy)
  );

  // Reference model: mode as integer, remaining recovery cycles, tag of last rule.
  int    m_mode = 0;
  int    m_left = 0;
  bit    m_ill  = 1'b0;
  string m_tag  = "R1";

  always @(posedge clk) begin
    bit q, rf, fall, rise;
    int nm; bit ni; int nl; string nt;
    q    = cs_n || (ras_n && cas_n && we_n);
    rf   = !cs_n && !ras_n && !cas_n && we_n;
    fall = cke_prev && !cke_now;
    rise = !cke_prev && cke_now;
    nm = m_mode; ni = 1'b0; nl = (m_left > 0) ? m_left - 1 : 0; nt = "R11";
    if (!rst_n) begin
      nm = 0; nl = 0; nt = "R1";
    end else if (m_mode == 0 && m_left > 0) begin
      nt = "R10";
      if (!q || fall) ni = 1'b1;
    end else if (m_mode == 0) begin
      if (fall && !banks_idle) begin nm = 3; nt = "R4"; end
      else if (fall && q) begin nm = 1; nt = "R2"; end
      else if (fall && rf) begin nm = 2; nt = "R3"; end
      else if (fall) begin ni = 1'b1; nt = "R3"; end
    end else if (m_mode == 3) begin
      nt = "R5";
      if (cke_now) nm = 0;
    end else begin
      if (cke_prev) begin ni = 1'b1; nt = "R9"; end
      else if (!rise) nt = "R8";
      else if (!q) begin ni = 1'b1; nt = "R8"; end
      else if (m_mode == 1) begin nm = 0; nt = "R6"; end
      else begin nm = 0; nl = TRC; nt = "R7"; end
    end
    m_mode <= nm; m_ill <= ni; m_left <= nl; m_tag <= nt;
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (int'(mode) != m_mode || illegal != m_ill || busy != (m_left > 0)) begin
        errors++;
        $display("FAIL %s (R12 timing) mode=%0d ill=%0b busy=%0b expected mode=%0d ill=%0b busy=%0b",
                 m_tag, mode, illegal, busy, m_mode, m_ill, (m_left > 0));
      end
    end
  end

  // Command codes: 0 deselect, 1 nop, 2 refresh, 3 activate, 4 read
  task automatic drive(input bit cp, input bit cn, input int cmd, input bit idle);
    @(negedge clk);
    cke_prev = cp; cke_now = cn; banks_idle = idle;
    case (cmd)
      0: {cs_n, ras_n, cas_n, we_n} = 4'b1010;
      1: {cs_n, ras_n, cas_n, we_n} = 4'b0111;
      2: {cs_n, ras_n, cas_n, we_n} = 4'b0001;
      3: {cs_n, ras_n, cas_n, we_n} = 4'b0011;
      default: {cs_n, ras_n, cas_n, we_n} = 4'b0101;
    endcase
  endtask

  initial begin
    repeat (3) drive(1, 1, 1, 1);     // R1 during reset
    rst_n = 1'b1;
    drive(1, 1, 3, 1);                // R11 steady high
    drive(1, 0, 1, 1);                // R2 enter power-down
    drive(0, 0, 3, 1);                // R8 ignored
    drive(0, 1, 4, 1);                // R8 illegal exit
    drive(1, 1, 1, 1);                // R9 invalid prev high
    drive(0, 1, 0, 1);                // R6 exit
    drive(1, 0, 2, 1);                // R3 enter self-refresh
    drive(0, 0, 1, 1);
    drive(0, 1, 1, 1);                // R7 exit, busy starts
    drive(1, 1, 3, 1);                // R10 bad command while busy
    drive(1, 0, 1, 1);                // R10 fall while busy
    for (int i = 0; i < TRC + 1; i++) drive(1, 1, 1, 1);
    drive(1, 0, 4, 1);                // R3 illegal entry command
    drive(1, 0, 1, 0);                // R4 suspend
    drive(0, 0, 4, 0);                // R5 stay
    drive(0, 1, 4, 0);                // R5 leave
    for (int i = 0; i < 4000; i++) begin
      int r; bit cn, cp; int cmd;
      r   = $urandom_range(0, 99);
      cn  = (r < 70) ? cke_now : ~cke_now;
      cp  = ($urandom_range(0, 99) < 94) ? cke_now : ~cke_now;
      r   = $urandom_range(0, 99);
      cmd = (r < 35) ? 1 : (r < 60) ? 0 : (r < 80) ? 2 : (r < 90) ? 3 : 4;
      drive(cp, cn, cmd, $urandom_range(0, 99) < 75);
    end
    drive(1, 1, 1, 1);
    @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule